// File: doc/BRIEF.md
# Camera Byte Stream Pixel Decoder

This block sits on the host side of an 8-bit parallel camera link. On each sampling edge of the camera's data clock it captures one data byte along with the line-valid (HD) and frame (VD) qualifiers. It then rebuilds pixels from consecutive bytes. The bytes are grouped as U, Y, V, Y quadruples for YUV 4:2:2, or as low/high pairs for RGB565. Bytes that arrive while HD is low are blanking filler and are dropped.

Pixels leave on one of two streams. The YUV stream gives each luma sample together with the chroma pair it shares. The RGB stream gives a 16-bit 5:6:5 word. Alongside the streams the block produces a start-of-frame strobe, an end-of-line strobe, a running pixel count for the current frame and a sticky error flag for lines with an odd byte count. The format select is only taken up at the start of a frame, so the host can change it at any time without breaking a frame in progress.

Top module: `cam_pixel_decoder`

## Requirements
- R1: After reset, `yuvValid`, `rgbValid`, `sofOut`, `eolOut` and `lineErr` are 0 and `pixCount` is 0.
- R2: In YUV format the bytes of a line arrive as U, Ya, V, Yb. Two pixels are produced: (y=Ya, u=U, v=V) and then (y=Yb, u=U, v=V). The first pixel is valid two sampling edges after the edge that captures V. The second is valid on the next edge.
- R3: In RGB format the first byte of a pair holds green[2:0] in bits 7..5 and blue[4:0] in bits 4..0. The second byte holds red[4:0] in bits 7..3 and green[5:3] in bits 2..0. `rgbOut` is {red, green, blue} in 5:6:5 order, which equals {second byte, first byte}. It is valid two edges after the second byte is captured.
- R4: A byte captured while HD is low never produces a pixel, whatever its value (0x00 and 0x80 included).
- R5: Byte grouping restarts at offset 0 on every rising edge of HD, so a short line does not shift the grouping of the next line.
- R6: If HD falls after an odd number of bytes in the line, `lineErr` is set. Once set, it stays set until reset.
- R7: `sofOut` pulses for exactly one cycle together with the first pixel that follows a VD rising edge. It does not pulse again until the next VD rise.
- R8: `pixCount` clears to 0 on a VD rising edge and rises by one with every emitted pixel. In the cycle a pixel is valid, it already includes that pixel.
- R9: The format select (`rgbModeIn`: 0 = YUV, 1 = RGB) is latched only on a VD rising edge. Changing it between VD rises has no effect.
- R10: `eolOut` is a one-cycle pulse in the cycle right after the last pixel of a line is valid. It also fires when HD falls in the same cycle as a VD rise.
- R11: `yuvValid` and `rgbValid` are never high together, and no pixel is valid in the cycle `eolOut` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dclk | input | 1 | Camera data clock |
| rstN | input | 1 | Asynchronous active-low reset |
| camByte | input | 8 | Camera data byte |
| hdIn | input | 1 | Line-valid qualifier, high during active bytes |
| vdIn | input | 1 | Frame qualifier, rising edge starts a frame |
| rgbModeIn | input | 1 | Format select: 0 YUV 4:2:2, 1 RGB565 |
| yuvValid | output | 1 | YUV pixel valid |
| yOut | output | 8 | Luma of the current pixel |
| uOut | output | 8 | Shared U of the current pixel |
| vOut | output | 8 | Shared V of the current pixel |
| rgbValid | output | 1 | RGB pixel valid |
| rgbOut | output | 16 | RGB565 pixel {r[4:0], g[5:0], b[4:0]} |
| sofOut | output | 1 | First pixel of a frame |
| eolOut | output | 1 | Line finished |
| lineErr | output | 1 | Sticky odd-byte-line error |
| pixCount | output | 20 | Pixels emitted since the last VD rise |

## Verification
Two events can fall in the same sampling cycle: the end of a line (HD falling) and the start of a new frame (VD rising). The bench provokes this by dropping HD and raising VD on the same byte, right after a complete RGB line. It also flips the format select just before that byte. The result is judged correct when all of the following hold: the end-of-line pulse still appears, the pixel count reads zero afterwards, the next line decodes in the newly selected format, and that line's first pixel carries the start-of-frame strobe with a count of one.

// File: rtl/cam_dec_pkg.sv
package cam_dec_pkg;
  localparam int BYTE_W  = 8;
  localparam int PHASE_W = 2;
  localparam int RGB_W   = 2 * BYTE_W;

  // strobes from control to datapath, one per byte role
  typedef struct packed {
    logic capFirst;   // U byte or RGB low byte
    logic capSecond;  // first luma of a pair
    logic emitYuvA;   // V byte: emit first pixel of pair
    logic emitYuvB;   // second luma: emit second pixel
    logic emitRgb;    // RGB high byte: emit pixel
  } dpStrobe_t;
endpackage

// File: rtl/cam_dec_ctrl.sv
module cam_dec_ctrl
  import cam_dec_pkg::*;
#(
  parameter int COUNT_W = 20
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hdIn,
  input  logic               vdIn,
  input  logic               modeIn,
  output dpStrobe_t          strobe,
  output logic               sofOut,
  output logic               eolOut,
  output logic               lineErr,
  output logic [COUNT_W-1:0] pixCount
);
  logic hdReg, vdReg, hdPrev, vdPrev;
  logic modeReg, sofPend;
  logic [PHASE_W-1:0] phaseCnt, byteIdx;
  logic hdRise, hdFall, vdRise, anyEmit;

  // qualifier sampling and edge history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdReg  <= 1'b0;
      vdReg  <= 1'b0;
      hdPrev <= 1'b0;
      vdPrev <= 1'b0;
    end else begin
      hdReg  <= hdIn;
      vdReg  <= vdIn;
      hdPrev <= hdReg;
      vdPrev <= vdReg;
    end
  end

  always_comb begin
    hdRise  = hdReg & ~hdPrev;
    hdFall  = ~hdReg & hdPrev;
    vdRise  = vdReg & ~vdPrev;
    byteIdx = hdRise ? '0 : phaseCnt;
    strobe.capFirst  = hdReg & (modeReg ? ~byteIdx[0] : (byteIdx == 2'd0));
    strobe.capSecond = hdReg & ~modeReg & (byteIdx == 2'd1);
    strobe.emitYuvA  = hdReg & ~modeReg & (byteIdx == 2'd2);
    strobe.emitYuvB  = hdReg & ~modeReg & (byteIdx == 2'd3);
    strobe.emitRgb   = hdReg & modeReg & byteIdx[0];
    anyEmit = strobe.emitYuvA | strobe.emitYuvB | strobe.emitRgb;
  end

  // byte phase, format latch, frame and line bookkeeping
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
      modeReg  <= 1'b0;
      sofPend  <= 1'b0;
      sofOut   <= 1'b0;
      eolOut   <= 1'b0;
      lineErr  <= 1'b0;
      pixCount <= '0;
    end else begin
      phaseCnt <= hdReg ? byteIdx + 1'b1 : '0;
      if (vdRise) modeReg <= modeIn;
      sofPend  <= vdRise | (sofPend & ~anyEmit);
      sofOut   <= sofPend & anyEmit & ~vdRise;
      eolOut   <= hdFall;
      if (hdFall && phaseCnt[0]) lineErr <= 1'b1;
      if (vdRise)       pixCount <= '0;
      else if (anyEmit) pixCount <= pixCount + 1'b1;
    end
  end

  p_blank_ignored_r4: assert property (@(posedge clk) disable iff (!rstN)
    !hdReg |-> !(strobe.emitYuvA || strobe.emitYuvB || strobe.emitRgb));
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    lineErr |=> lineErr);
  p_count_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pixCount != $past(pixCount)) |-> (pixCount == '0 || pixCount == $past(pixCount) + 1'b1));
  p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !vdRise |=> $stable(modeReg));
endmodule

// File: rtl/cam_dec_datapath.sv
module cam_dec_datapath
  import cam_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] byteIn,
  input  dpStrobe_t         strobe,
  output logic              yuvValid,
  output logic [BYTE_W-1:0] yOut,
  output logic [BYTE_W-1:0] uOut,
  output logic [BYTE_W-1:0] vOut,
  output logic              rgbValid,
  output logic [RGB_W-1:0]  rgbOut
);
  logic [BYTE_W-1:0] byteReg, holdFirst, holdLuma, holdV;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteReg   <= '0;
      holdFirst <= '0;
      holdLuma  <= '0;
      holdV     <= '0;
      yuvValid  <= 1'b0;
      rgbValid  <= 1'b0;
      yOut      <= '0;
      uOut      <= '0;
      vOut      <= '0;
      rgbOut    <= '0;
    end else begin
      byteReg  <= byteIn;
      yuvValid <= strobe.emitYuvA | strobe.emitYuvB;
      rgbValid <= strobe.emitRgb;
      if (strobe.capFirst)  holdFirst <= byteReg;
      if (strobe.capSecond) holdLuma  <= byteReg;
      if (strobe.emitYuvA) begin
        holdV <= byteReg;
        yOut  <= holdLuma;
        uOut  <= holdFirst;
        vOut  <= byteReg;
      end
      if (strobe.emitYuvB) begin
        yOut <= byteReg;
        uOut <= holdFirst;
        vOut <= holdV;
      end
      // high byte {r, g[5:3]} above low byte {g[2:0], b} gives 5:6:5
      if (strobe.emitRgb) rgbOut <= {byteReg, holdFirst};
    end
  end

  p_one_stream_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(yuvValid && rgbValid));
endmodule

// File: rtl/cam_pixel_decoder.sv
module cam_pixel_decoder
  import cam_dec_pkg::*;
#(
  parameter int COUNT_W     = 20,
  parameter bit INVERT_DCLK = 1'b0
) (
  input  logic               dclk,
  input  logic               rstN,
  input  logic [BYTE_W-1:0]  camByte,
  input  logic               hdIn,
  input  logic               vdIn,
  input  logic               rgbModeIn,
  output logic               yuvValid,
  output logic [BYTE_W-1:0]  yOut,
  output logic [BYTE_W-1:0]  uOut,
  output logic [BYTE_W-1:0]  vOut,
  output logic               rgbValid,
  output logic [RGB_W-1:0]   rgbOut,
  output logic               sofOut,
  output logic               eolOut,
  output logic               lineErr,
  output logic [COUNT_W-1:0] pixCount
);
  logic sampleClk;
  dpStrobe_t strobe;

  generate
    if (INVERT_DCLK) begin : g_fall_edge
      assign sampleClk = ~dclk;
    end else begin : g_rise_edge
      assign sampleClk = dclk;
    end
  endgenerate

  cam_dec_ctrl #(.COUNT_W(COUNT_W)) u_ctrl (
    .clk(sampleClk), .rstN(rstN), .hdIn(hdIn), .vdIn(vdIn), .modeIn(rgbModeIn),
    .strobe(strobe), .sofOut(sofOut), .eolOut(eolOut), .lineErr(lineErr),
    .pixCount(pixCount)
  );

  cam_dec_datapath u_dp (
    .clk(sampleClk), .rstN(rstN), .byteIn(camByte), .strobe(strobe),
    .yuvValid(yuvValid), .yOut(yOut), .uOut(uOut), .vOut(vOut),
    .rgbValid(rgbValid), .rgbOut(rgbOut)
  );

  p_sof_on_pixel_r7: assert property (@(posedge sampleClk) disable iff (!rstN)
    sofOut |-> (yuvValid || rgbValid));
  p_eol_no_pixel_r10: assert property (@(posedge sampleClk) disable iff (!rstN)
    eolOut |-> !(yuvValid || rgbValid));
endmodule

// File: tb/cam_pixel_decoder_bench.sv
module cam_pixel_decoder_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] camByte = 8'h80;
  logic hdIn = 1'b0, vdIn = 1'b0, rgbModeIn = 1'b0;
  logic yuvValid, rgbValid, sofOut, eolOut, lineErr;
  logic [7:0] yOut, uOut, vOut;
  logic [15:0] rgbOut;
  logic [19:0] pixCount;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  // capture of emitted pixels
  logic [23:0] capPix [0:31];
  bit          capRgb [0:31];
  int          capCnt [0:31];
  int nPix = 0, nSof = 0, sofIdx = -1, nEol = 0, eolLate = 0;
  bit prevValid = 1'b0;

  always #10 clk = ~clk;

  cam_pixel_decoder u_cam_pixel_decoder (
    .dclk(clk), .rstN(rstN), .camByte(camByte), .hdIn(hdIn), .vdIn(vdIn),
    .rgbModeIn(rgbModeIn), .yuvValid(yuvValid), .yOut(yOut), .uOut(uOut),
    .vOut(vOut), .rgbValid(rgbValid), .rgbOut(rgbOut), .sofOut(sofOut),
    .eolOut(eolOut), .lineErr(lineErr), .pixCount(pixCount)
  );

  always @(negedge clk) begin
    if (rstN) begin
      if ((yuvValid || rgbValid) && nPix < 32) begin
        capPix[nPix] = rgbValid ? {8'h00, rgbOut} : {yOut, uOut, vOut};
        capRgb[nPix] = rgbValid;
        capCnt[nPix] = int'(pixCount);
        if (sofOut) sofIdx = nPix;
        nPix++;
      end
      if (sofOut) nSof++;
      if (eolOut) begin
        nEol++;
        if (!prevValid) eolLate++;
      end
      prevValid = yuvValid || rgbValid;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] b, input logic h, input logic v);
    @(negedge clk);
    camByte = b; hdIn = h; vdIn = v;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive((i % 2) ? 8'h00 : 8'h80, 1'b0, 1'b0);
  endtask

  task automatic clearCap();
    nPix = 0; nSof = 0; sofIdx = -1; nEol = 0; eolLate = 0;
  endtask

  task automatic frameStart();
    drive(8'h80, 1'b0, 1'b1);
    drive(8'h00, 1'b0, 1'b0);
    idle(2);
  endtask

  task automatic sendLine(input logic [7:0] b [], input int n);
    for (int i = 0; i < n; i++) drive(b[i], 1'b1, 1'b0);
  endtask

  task automatic t_reset();
    check(!yuvValid && !rgbValid, "R1 valids low", {yuvValid, rgbValid}, 0);
    check(!sofOut && !eolOut, "R1 strobes low", {sofOut, eolOut}, 0);
    check(!lineErr, "R1 error low", lineErr, 0);
    check(pixCount == 0, "R1 count zero", pixCount, 0);
  endtask

  task automatic t_yuv_latency();
    clearCap();
    drive(8'h11, 1'b1, 1'b0);
    drive(8'h22, 1'b1, 1'b0);
    drive(8'h33, 1'b1, 1'b0);
    @(negedge clk);
    check(!yuvValid, "R2 not yet valid one edge after V", yuvValid, 0);
    camByte = 8'h44;
    @(negedge clk);
    check(yuvValid && {yOut, uOut, vOut} == 24'h221133, "R2 first pixel",
          {yuvValid, yOut, uOut, vOut}, 32'h1221133);
    hdIn = 1'b0; camByte = 8'h80;
    @(negedge clk);
    check(yuvValid && {yOut, uOut, vOut} == 24'h441133, "R2 second pixel",
          {yuvValid, yOut, uOut, vOut}, 32'h1441133);
    idle(4);
  endtask

  task automatic t_yuv_line();
    logic [7:0] ln [] = '{8'h10, 8'hA0, 8'h20, 8'hA1, 8'h30, 8'hA2, 8'h40, 8'hA3};
    frameStart();
    clearCap();
    idle(6);  // blanking 0x00 / 0x80 with HD low
    check(nPix == 0, "R4 blanking bytes emit nothing", nPix, 0);
    sendLine(ln, 8);
    idle(4);
    check(nPix == 4, "R2 four pixels from eight bytes", nPix, 4);
    check(capPix[0] == 24'hA01020 && capPix[1] == 24'hA11020, "R2 pair one",
          capPix[1], 24'hA11020);
    check(capPix[2] == 24'hA23040 && capPix[3] == 24'hA33040, "R2 pair two",
          capPix[3], 24'hA33040);
    check(capCnt[0] == 1 && capCnt[3] == 4, "R8 count per pixel", capCnt[3], 4);
    check(nSof == 1 && sofIdx == 0, "R7 sof on first pixel", sofIdx, 0);
    check(nEol == 1 && eolLate == 0, "R10 eol right after last pixel", nEol, 1);
    sendLine(ln, 4);
    idle(4);
    check(nSof == 1, "R7 no second sof inside frame", nSof, 1);
    check(pixCount == 6, "R8 count spans lines", pixCount, 6);
  endtask

  task automatic t_mode_switch();
    logic [7:0] ln [] = '{8'hA7, 8'h5C, 8'h3F, 8'hC1};
    rgbModeIn = 1'b1;
    clearCap();
    sendLine(ln, 4);
    idle(4);
    check(nPix == 2 && !capRgb[0] && !capRgb[1], "R9 select ignored mid-frame",
          {capRgb[0], capRgb[1]}, 0);
    check(capPix[0] == 24'h5CA73F, "R9 still YUV decode", capPix[0], 24'h5CA73F);
    frameStart();
    clearCap();
    sendLine(ln, 4);
    idle(4);
    check(nPix == 2 && capRgb[0] && capRgb[1], "R3 RGB stream used", nPix, 2);
    // red=01011 green=100101 blue=00111 -> 0x5CA7
    check(capPix[0][15:0] == 16'h5CA7, "R3 rgb565 packing", capPix[0][15:0], 16'h5CA7);
    check(capPix[1][15:0] == 16'hC13F, "R3 second rgb pixel", capPix[1][15:0], 16'hC13F);
  endtask

  task automatic t_odd_line();
    logic [7:0] sh [] = '{8'h01, 8'h02, 8'h03};
    logic [7:0] ln [] = '{8'h34, 8'h12, 8'h78, 8'h56};
    check(!lineErr, "R6 no error after even lines", lineErr, 0);
    clearCap();
    sendLine(sh, 3);
    idle(3);
    check(lineErr, "R6 odd line flags error", lineErr, 1);
    check(nPix == 1 && capPix[0][15:0] == 16'h0201, "R5 short line pixel", capPix[0][15:0], 16'h0201);
    clearCap();
    sendLine(ln, 4);
    idle(4);
    check(nPix == 2 && capPix[0][15:0] == 16'h1234 && capPix[1][15:0] == 16'h5678,
          "R5 grouping restarts at HD rise", capPix[1][15:0], 16'h5678);
    check(lineErr, "R6 error sticky", lineErr, 1);
  endtask

  task automatic t_coincide();
    logic [7:0] ln [] = '{8'h34, 8'h12, 8'h78, 8'h56};
    logic [7:0] yl [] = '{8'h61, 8'h62, 8'h63, 8'h64};
    clearCap();
    sendLine(ln, 4);
    rgbModeIn = 1'b0;
    drive(8'h80, 1'b0, 1'b1);  // HD falls and VD rises on the same byte
    drive(8'h00, 1'b0, 1'b0);
    idle(3);
    check(nEol == 1 && eolLate == 0, "R10 eol with frame start", nEol, 1);
    check(pixCount == 0, "R8 count cleared at VD rise", pixCount, 0);
    clearCap();
    sendLine(yl, 4);
    idle(4);
    check(nPix == 2 && !capRgb[0] && capPix[0] == 24'h626163, "R9 new format taken",
          capPix[0], 24'h626163);
    check(nSof == 1 && sofIdx == 0 && capCnt[0] == 1, "R7 sof after coincident start",
          capCnt[0], 1);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    idle(3);
    t_reset();
    t_yuv_latency();
    t_yuv_line();
    t_mode_switch();
    t_odd_line();
    t_coincide();
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end
endmodule